// File: doc/BRIEF.md
# Transmit Channel-Status Bit Generator

This block supplies the channel-status bit that a two-channel serial audio transmitter carries in every frame. A block is 192 frames long. An index counter locates the current frame in the block. On each frame strobe the block picks the status bit for that index and presents it for both sub-frames; a sub-frame select input chooses which of the two registered bits appears on the output. The status bit comes either from a 192-bit transmit register or from an auxiliary serial input. An external status pin can be ORed in on top of either source.

Two field rewrites sit on the output path. In consumer mode (emitted bit 0 equal to 0), bits 20 to 23 carry a per-sub-frame channel code chosen by a stereo control. In professional mode (emitted bit 0 equal to 1), with CRC enabled, the last eight bits are replaced by a CRC-8 computed over the bits actually sent. Host writes to the transmit register are double-buffered and only reach the output at a block start. A copy request loads the transmit register from a 192-bit received-status register, which a receiver fills bit by bit, in one step.

Top module: `cs_tx_gen`

## Requirements
- R1: After reset `bit_index` is 191, `cs_bit` is 0 and `copy_busy` is 0. A frame strobe with `block_start` high sets `bit_index` to 0. Every other frame strobe advances it by one, and it wraps from 191 to 0.
- R2: With `src_reg`=1, bit i of the active transmit register is emitted for both sub-frames at index i, unless a rewrite below applies. Bit i is bit i%8 of byte i/8. Outputs change only on the clock edge that samples `frame_tick`=1, and `sub_sel`=0/1 selects sub-frame 1/2.
- R3: With `src_reg`=0, the value of `aux_cs` sampled with the frame strobe is emitted in place of the register bit.
- R4: When `pin_en`=1 and `passthru`=0, the emitted bit is the OR of the selected source and `ext_cs`. When `passthru`=1 or `pin_en`=0, `ext_cs` has no effect.
- R5: When the bit emitted at index 0 of the block is 0 (consumer), indices 20..23 carry 1,0,0,0 in sub-frame 1 and 0,1,0,0 in sub-frame 2 if `stereo`=1, and 0,0,0,0 in both if `stereo`=0.
- R6: When the bit emitted at index 0 is 1 and `crc_en`=1, indices 184..191 carry, most significant bit first, the CRC-8 (polynomial x^8+x^4+x^3+x^2+1, initial value 0xFF, each input bit shifted in at the top) of the emitted sub-frame 1 bits 0..183.
- R7: With `crc_en`=0 in professional mode, or in consumer mode whatever `crc_en` is, indices 184..191 carry the selected source bits unchanged.
- R8: A write (`wr_en`, byte `wr_addr`, `wr_data`) updates a shadow register. The shadow is copied to the active register at every block start, so a write made mid-block first appears in the next block.
- R9: A 0-to-1 transition of `copy_req` copies all 192 received bits into the shadow and sets `copy_busy`. `copy_busy` clears at the next block start, and that block emits the copied bits.
- R10: A host write is ignored while `copy_busy` is 1, and also in the cycle in which `copy_req` rises.
- R11: When `copy_req` rises in the same cycle as a block-start frame strobe, that block emits the shadow contents from before the copy, `copy_busy` stays 1, and the copied bits appear from the following block start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_tick | input | 1 | One-cycle strobe per frame |
| block_start | input | 1 | Marks the strobed frame as index 0 |
| sub_sel | input | 1 | 0 = sub-frame 1 bit, 1 = sub-frame 2 bit on `cs_bit` |
| src_reg | input | 1 | 1 = transmit register source, 0 = auxiliary input |
| pin_en | input | 1 | Enables ORing of `ext_cs` |
| passthru | input | 1 | Pass-through mode; forces `ext_cs` to be ignored |
| aux_cs | input | 1 | Auxiliary serial status bit, sampled with the frame strobe |
| ext_cs | input | 1 | External status pin, sampled with the frame strobe |
| stereo | input | 1 | Consumer channel-code control |
| crc_en | input | 1 | Professional CRC insertion enable |
| wr_en | input | 1 | Host byte write strobe |
| wr_addr | input | 5 | Byte number 0..23 |
| wr_data | input | 8 | Byte value |
| rx_wr | input | 1 | Received-status bit write strobe |
| rx_idx | input | 8 | Received bit index 0..191 |
| rx_bit | input | 1 | Received bit value |
| copy_req | input | 1 | Copy request; acts on its rising edge |
| copy_busy | output | 1 | Copy pending until the next block start |
| cs_bit | output | 1 | Status bit of the selected sub-frame |
| bit_index | output | 8 | Index of the current frame within the block |

## Verification
Three events can land in one clock: a copy request rising, a host write, and a block-start frame strobe. A copy rising together with a host write must drop the write. A copy rising together with a block start must let the old shadow reach the output for that block and hold the copied bits back until the following block. The bench drives each of these coincidences on purpose and keeps a bench-side shadow, active and busy model. It then checks every emitted bit of both sub-frames over the following two blocks against that model, and checks `copy_busy` after every frame.

// File: rtl/cs_tx_pkg.sv
// Shared constants and the serial CRC-8 step for the channel-status generator.
// Assumes a CRC of exactly eight bits, inserted at the end of the block.
package cs_tx_pkg;
    localparam int          CRC_W    = 8;
    localparam logic [7:0]  CRC_POLY = 8'h1D;   // x^8+x^4+x^3+x^2+1
    localparam logic [7:0]  CRC_INIT = 8'hFF;

    // Shift one bit into the CRC, most significant bit first.
    function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic d);
        logic fb;
        fb = c[7] ^ d;
        return {c[6:0], 1'b0} ^ (fb ? CRC_POLY : 8'h00);
    endfunction
endpackage

// File: rtl/cs_status_store.sv
// Holds the received-status register and the double-buffered transmit register
// (shadow plus active). It also handles the edge-triggered receive-to-transmit
// copy. The indexed transmit bit is read from the shadow during a block-start
// frame, because the shadow becomes active on that edge.
// Assumes BLOCK_BITS is a multiple of 8.
module cs_status_store #(
    parameter int BLOCK_BITS = 192,
    parameter int IDX_W      = $clog2(BLOCK_BITS),
    parameter int ADDR_W     = $clog2(BLOCK_BITS / 8)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              blk,
    input  logic [IDX_W-1:0]  idx_sel,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              rx_wr,
    input  logic [IDX_W-1:0]  rx_idx,
    input  logic              rx_bit,
    input  logic              copy_req,
    output logic              copy_busy,
    output logic              reg_bit
);
    localparam int NBYTES = BLOCK_BITS / 8;

    logic [7:0]            shadow_q [NBYTES];
    logic [7:0]            active_q [NBYTES];
    logic [BLOCK_BITS-1:0] rx_q;
    logic                  copy_q;
    logic                  busy_q;
    logic                  copy_rise;
    logic                  wr_ok;

    assign copy_rise = copy_req & ~copy_q;
    assign wr_ok     = wr_en & ~busy_q & ~copy_rise;
    assign copy_busy = busy_q;

    // Remembers the previous copy request for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) copy_q <= 1'b0;
        else        copy_q <= copy_req;
    end

    // Copy-pending flag: set by a copy, cleared by the block start that publishes it.
    always_ff @(posedge clk) begin
        if (!rst_n)         busy_q <= 1'b0;
        else if (copy_rise) busy_q <= 1'b1;
        else if (blk)       busy_q <= 1'b0;
    end

    // Received status, written one bit at a time by the receiver.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else if (rx_wr) begin
            for (int i = 0; i < BLOCK_BITS; i++) begin
                if (rx_idx == IDX_W'(i)) rx_q[i] <= rx_bit;
            end
        end
    end

    for (genvar g = 0; g < NBYTES; g++) begin : g_byte
        // Shadow byte: a copy takes priority over a host write.
        always_ff @(posedge clk) begin
            if (!rst_n)                                shadow_q[g] <= 8'h00;
            else if (copy_rise)                        shadow_q[g] <= rx_q[g*8 +: 8];
            else if (wr_ok && wr_addr == ADDR_W'(g))   shadow_q[g] <= wr_data;
        end
        // Active byte: follows the shadow at each block start.
        always_ff @(posedge clk) begin
            if (!rst_n)   active_q[g] <= 8'h00;
            else if (blk) active_q[g] <= shadow_q[g];
        end
    end

    // Selects the indexed bit from the copy that is live for this frame.
    always_comb begin
        reg_bit = 1'b0;
        for (int b = 0; b < NBYTES; b++) begin
            if (idx_sel[IDX_W-1:3] == (IDX_W-3)'(b)) begin
                reg_bit = blk ? shadow_q[b][idx_sel[2:0]] : active_q[b][idx_sel[2:0]];
            end
        end
    end
endmodule

// File: rtl/cs_crc_unit.sv
// Bit-serial CRC-8 over the emitted sub-frame 1 bits. It reloads at index 0,
// accumulates up to index CRC_START-1, and then shifts the result out MSB first.
// Assumes idx_cur is the index of the frame being strobed.
module cs_crc_unit #(
    parameter int IDX_W     = 8,
    parameter int CRC_START = 184
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_tick,
    input  logic [IDX_W-1:0] idx_cur,
    input  logic             emit_bit,
    output logic             crc_msb
);
    import cs_tx_pkg::*;

    logic [CRC_W-1:0] crc_q;

    assign crc_msb = crc_q[CRC_W-1];

    // Reload, accumulate or shift out, once per frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q <= '0;
        end else if (frame_tick) begin
            if (idx_cur == '0)                       crc_q <= crc8_step(CRC_INIT, emit_bit);
            else if (idx_cur < IDX_W'(CRC_START))    crc_q <= crc8_step(crc_q, emit_bit);
            else                                     crc_q <= {crc_q[CRC_W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/cs_bit_former.sv
// Advances the block index and picks the source bit. It merges in the external
// pin, applies the consumer channel-code rewrite and the professional CRC
// substitution, and registers one bit per sub-frame.
// Assumes block_start has meaning only together with frame_tick.
module cs_bit_former #(
    parameter int BLOCK_BITS = 192,
    parameter int IDX_W      = $clog2(BLOCK_BITS),
    parameter int NIB_LO     = 20,
    parameter int CRC_START  = 184
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_tick,
    input  logic             block_start,
    input  logic             sub_sel,
    input  logic             src_reg,
    input  logic             pin_en,
    input  logic             passthru,
    input  logic             aux_cs,
    input  logic             ext_cs,
    input  logic             stereo,
    input  logic             crc_en,
    input  logic             reg_bit,
    input  logic             crc_msb,
    output logic             blk,
    output logic [IDX_W-1:0] idx_cur,
    output logic [IDX_W-1:0] idx_q,
    output logic             emit_a,
    output logic             pro_q,
    output logic             cs_bit
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(BLOCK_BITS - 1);

    logic merged, pro_now, in_nib, crc_zone, emit_b;
    logic cs_a_q, cs_b_q;

    assign blk     = frame_tick & block_start;
    assign idx_cur = blk ? '0 : ((idx_q == LAST) ? '0 : idx_q + IDX_W'(1));

    // Source choice, the external OR and both field rewrites for the strobed index.
    always_comb begin
        merged   = (src_reg ? reg_bit : aux_cs) | (pin_en & ~passthru & ext_cs);
        pro_now  = (idx_cur == '0) ? merged : pro_q;
        in_nib   = (idx_cur >= IDX_W'(NIB_LO)) && (idx_cur < IDX_W'(NIB_LO + 4));
        crc_zone = crc_en & pro_now & (idx_cur >= IDX_W'(CRC_START));
        if (crc_zone) begin
            emit_a = crc_msb;
            emit_b = crc_msb;
        end else if (!pro_now && in_nib) begin
            emit_a = stereo & (idx_cur == IDX_W'(NIB_LO));
            emit_b = stereo & (idx_cur == IDX_W'(NIB_LO + 1));
        end else begin
            emit_a = merged;
            emit_b = merged;
        end
    end

    // Index, mode flag and per-sub-frame output registers, updated once per frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= LAST;
            pro_q  <= 1'b0;
            cs_a_q <= 1'b0;
            cs_b_q <= 1'b0;
        end else if (frame_tick) begin
            idx_q  <= idx_cur;
            cs_a_q <= emit_a;
            cs_b_q <= emit_b;
            if (idx_cur == '0) pro_q <= merged;
        end
    end

    assign cs_bit = sub_sel ? cs_b_q : cs_a_q;
endmodule

// File: rtl/cs_tx_gen.sv
// Top level of the transmit channel-status generator: the status store, the
// bit former and the CRC unit, wired together.
// Assumes frame_tick is a one-cycle strobe and the host writes whole bytes.
module cs_tx_gen #(
    parameter int BLOCK_BITS = 192,
    parameter int NIB_LO     = 20,
    parameter int IDX_W      = $clog2(BLOCK_BITS),
    parameter int ADDR_W     = $clog2(BLOCK_BITS / 8)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_tick,
    input  logic              block_start,
    input  logic              sub_sel,
    input  logic              src_reg,
    input  logic              pin_en,
    input  logic              passthru,
    input  logic              aux_cs,
    input  logic              ext_cs,
    input  logic              stereo,
    input  logic              crc_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              rx_wr,
    input  logic [IDX_W-1:0]  rx_idx,
    input  logic              rx_bit,
    input  logic              copy_req,
    output logic              copy_busy,
    output logic              cs_bit,
    output logic [IDX_W-1:0]  bit_index
);
    localparam int CRC_START = BLOCK_BITS - cs_tx_pkg::CRC_W;

    logic             blk, reg_bit, crc_msb, emit_a, pro_q;
    logic [IDX_W-1:0] idx_cur;

    cs_status_store #(.BLOCK_BITS(BLOCK_BITS), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_store (
        .clk(clk), .rst_n(rst_n), .blk(blk), .idx_sel(idx_cur),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rx_wr(rx_wr), .rx_idx(rx_idx), .rx_bit(rx_bit),
        .copy_req(copy_req), .copy_busy(copy_busy), .reg_bit(reg_bit)
    );

    cs_bit_former #(.BLOCK_BITS(BLOCK_BITS), .IDX_W(IDX_W), .NIB_LO(NIB_LO),
                    .CRC_START(CRC_START)) u_form (
        .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .block_start(block_start),
        .sub_sel(sub_sel), .src_reg(src_reg), .pin_en(pin_en), .passthru(passthru),
        .aux_cs(aux_cs), .ext_cs(ext_cs), .stereo(stereo), .crc_en(crc_en),
        .reg_bit(reg_bit), .crc_msb(crc_msb), .blk(blk), .idx_cur(idx_cur),
        .idx_q(bit_index), .emit_a(emit_a), .pro_q(pro_q), .cs_bit(cs_bit)
    );

    cs_crc_unit #(.IDX_W(IDX_W), .CRC_START(CRC_START)) u_crc (
        .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .idx_cur(idx_cur),
        .emit_bit(emit_a), .crc_msb(crc_msb)
    );
endmodule

// File: rtl/cs_tx_gen_chk.sv
// Temporal checks on the generator's ports and its latched mode flag.
// Assumes the default 192-bit block and channel code at indices 20..23.
module cs_tx_gen_chk #(
    parameter int IDX_W = 8,
    parameter int LAST  = 191
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_tick,
    input logic             block_start,
    input logic             sub_sel,
    input logic             copy_req,
    input logic             copy_busy,
    input logic             cs_bit,
    input logic [IDX_W-1:0] bit_index,
    input logic             pro_flag
);
    // R1
    idx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_tick && block_start) |=> (bit_index == '0));

    // R1
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_index <= IDX_W'(LAST));

    // R9
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(copy_busy) |-> $past(copy_req));

    // R9
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(copy_busy) |-> $past(frame_tick && block_start));

    // R5
    nib_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pro_flag && (bit_index == IDX_W'(22) || bit_index == IDX_W'(23))) |-> !cs_bit);

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_tick ##1 $stable(sub_sel) |-> $stable(cs_bit));
endmodule

bind cs_tx_gen cs_tx_gen_chk #(.IDX_W(IDX_W), .LAST(BLOCK_BITS - 1)) u_chk (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .block_start(block_start),
    .sub_sel(sub_sel), .copy_req(copy_req), .copy_busy(copy_busy), .cs_bit(cs_bit),
    .bit_index(bit_index), .pro_flag(pro_q)
);

// File: tb/tb_cs_tx_gen.sv
// Frame-by-frame comparison of both sub-frame bits against a bench-side model
// of the shadow, active, copy-pending and CRC state.
module tb_cs_tx_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_tick = 0, block_start = 0, sub_sel = 0;
    logic       src_reg = 1, pin_en = 0, passthru = 0, aux_cs = 0, ext_cs = 0;
    logic       stereo = 0, crc_en = 0, wr_en = 0, rx_wr = 0, rx_bit = 0, copy_req = 0;
    logic [4:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rx_idx = '0;
    logic       copy_busy, cs_bit;
    logic [7:0] bit_index;

    int n_chk = 0, n_fail = 0;

    logic [191:0] shadow_m = '0, act_m = '0, rx_m = '0;
    logic         busy_m = 0, pro_m = 0;
    logic [7:0]   crc_m = '0;
    int           idx_m = 191;

    cs_tx_gen dut (
        .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .block_start(block_start),
        .sub_sel(sub_sel), .src_reg(src_reg), .pin_en(pin_en), .passthru(passthru),
        .aux_cs(aux_cs), .ext_cs(ext_cs), .stereo(stereo), .crc_en(crc_en),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rx_wr(rx_wr),
        .rx_idx(rx_idx), .rx_bit(rx_bit), .copy_req(copy_req), .copy_busy(copy_busy),
        .cs_bit(cs_bit), .bit_index(bit_index)
    );

    always #2 clk = ~clk;

    function automatic logic [7:0] crc_step(input logic [7:0] c, input logic d);
        return {c[6:0], 1'b0} ^ ((c[7] ^ d) ? 8'h1D : 8'h00);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (index %0d)", req, act, exp, idx_m);
        end
    endtask

    // One frame: model update, drive, then check both sub-frames, index and busy.
    task automatic do_frame(input logic bs, input logic aux, input logic ext, input logic cp,
                            input string req);
        logic [191:0] src;
        logic m, pn, ea, eb;
        int i;
        src = bs ? shadow_m : act_m;
        i   = bs ? 0 : (idx_m == 191 ? 0 : idx_m + 1);
        m   = (src_reg ? src[i] : aux) | (pin_en & ~passthru & ext);
        pn  = (i == 0) ? m : pro_m;
        if (crc_en && pn && i >= 184) begin ea = crc_m[7]; eb = ea; end
        else if (!pn && i >= 20 && i <= 23) begin
            ea = stereo && (i == 20); eb = stereo && (i == 21);
        end else begin ea = m; eb = m; end
        if (i == 0)        crc_m = crc_step(8'hFF, ea);
        else if (i < 184)  crc_m = crc_step(crc_m, ea);
        else               crc_m = {crc_m[6:0], 1'b0};
        if (i == 0) pro_m = m;
        idx_m = i;
        if (bs) begin act_m = shadow_m; busy_m = 0; end
        if (cp) begin shadow_m = rx_m; busy_m = 1; end
        @(negedge clk);
        frame_tick = 1; block_start = bs; aux_cs = aux; ext_cs = ext; copy_req = cp;
        @(negedge clk);
        frame_tick = 0; block_start = 0; copy_req = 0; sub_sel = 0;
        #1 chk({req, " sub-frame 1"}, cs_bit, ea);
        sub_sel = 1;
        #1 chk({req, " sub-frame 2"}, cs_bit, eb);
        chk("R1 index", bit_index, idx_m);
        chk("R9 busy", copy_busy, busy_m);
    endtask

    task automatic run_block(input int n, input logic cp_first, input int wr_at, input string req);
        for (int f = 0; f < n; f++) begin
            if (f == wr_at) host_write(5'd2, 8'hA5, 1'b0);
            do_frame(f == 0, (f % 5) == 1, (f % 7) == 3, cp_first && f == 0, req);
        end
    endtask

    // Host byte write, optionally with a copy request in the same cycle.
    task automatic host_write(input logic [4:0] a, input logic [7:0] d, input logic cp);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d; copy_req = cp;
        if (cp) begin shadow_m = rx_m; busy_m = 1; end
        else if (!busy_m) shadow_m[a*8 +: 8] = d;
        @(negedge clk);
        wr_en = 0; copy_req = 0;
    endtask

    task automatic load_pattern(input int seed, input logic pro);
        for (int b = 0; b < 24; b++) begin
            logic [7:0] d;
            d = 8'((b * seed + 7) & 255);
            if (b == 0) d[0] = pro;
            host_write(5'(b), d, 1'b0);
        end
    endtask

    task automatic load_rx(input int seed, input logic pro);
        for (int i = 0; i < 192; i++) begin
            logic v;
            v = (i == 0) ? pro : (((i * seed) % 11) < 5);
            @(negedge clk);
            rx_wr = 1; rx_idx = 8'(i); rx_bit = v; rx_m[i] = v;
        end
        @(negedge clk);
        rx_wr = 0;
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        chk("R1 reset index", bit_index, 191);
        chk("R1 reset bit", cs_bit, 0);
        chk("R1 reset busy", copy_busy, 0);

        // Consumer with stereo on; crc_en on must have no effect in consumer mode.
        src_reg = 1; stereo = 1; crc_en = 1;
        load_pattern(53, 1'b0);
        run_block(192, 0, -1, "R2 R5 R7 consumer stereo");
        stereo = 0;
        run_block(192, 0, -1, "R5 consumer no stereo");
        // Professional with CRC; a mid-block write must wait for the next block.
        load_pattern(29, 1'b1);
        run_block(192, 0, 50, "R6 R8 pro crc");
        crc_en = 0;
        run_block(192, 0, -1, "R7 R8 pro no crc");
        // Auxiliary source, with the external pin merged and then ignored.
        src_reg = 0; pin_en = 1; passthru = 0; stereo = 1; crc_en = 1;
        run_block(192, 0, -1, "R3 R4 aux with pin");
        passthru = 1;
        run_block(192, 0, -1, "R4 pin ignored");
        // Copy that coincides with a host write, then a blocked write.
        src_reg = 1; pin_en = 0; passthru = 0;
        load_rx(7, 1'b1);
        host_write(5'd4, 8'h3C, 1'b1);
        #1 chk("R9 busy after copy", copy_busy, 1);
        host_write(5'd6, 8'hF0, 1'b0);
        run_block(192, 0, -1, "R9 R10 copied block");
        // Copy rising on a block-start frame is held back for one block.
        load_pattern(91, 1'b0);
        load_rx(3, 1'b0);
        run_block(192, 1, 20, "R11 R10 coincident copy");
        run_block(200, 0, -1, "R11 R1 copied and wrap");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule